// File: doc/BRIEF.md
# Early Redirect Recovery Read Selector

This block shortens the path from a backend misprediction to the recovered fetch state. The recovery record for each fetch-queue entry sits in storage with one cycle of read latency. Normally that read could only start after the final redirect names its queue index. Here the block starts the reads one cycle sooner. In that earlier cycle, four ALU paths each offer a candidate queue index, qualified by a common valid bit and a one-hot path mask. The block launches all four reads in parallel, because the arbitration among the paths has not yet been decided.

In the next cycle the final redirect arrives with the index that won arbitration. The block compares that index with each candidate that was enabled in the previous cycle. On a match it registers the matching read result and presents it one cycle after the redirect. If nothing matches, it issues a single ordinary read for the redirect index and presents the data one cycle later than on a match. The path mask is cleared every cycle that carries no early request. Early candidates are therefore only usable by a redirect in the very next cycle.

Top module: `early_redirect_sel`

## Requirements
- R1: While reset is held, and in the first cycle after it, `out_vld`, `nrm_rd_en` and every bit of `ahd_rd_en` are 0, provided no request is driven.
- R2: In the cycle of an early request, bit i of `ahd_rd_en` equals `early_vld` AND `early_sel[i]`. `ahd_rd_addr` carries `early_idx` unchanged, with path i's 6-bit index at bits [6*i+5 : 6*i].
- R3: A redirect that arrives in the cycle right after an early request matches when some path i had `early_sel[i]`=1 and an index equal to `redir_idx`. A match raises no ordinary read. In the next cycle `out_vld`=1 and `out_data` holds the stored record for `redir_idx`.
- R4: A path whose `early_sel` bit was 0, or any path when `early_vld` was 0, never produces a match, even if its index equals `redir_idx`.
- R5: A redirect with no match asserts `nrm_rd_en` with `nrm_rd_addr`=`redir_idx` in the same cycle. Two cycles after the redirect, `out_vld`=1 and `out_data` holds the record for `redir_idx`. The cycle in between shows `out_vld`=0.
- R6: Early candidates are valid for one cycle only. A redirect that comes two cycles after an early request and has no newer request before it takes the ordinary-read path.
- R7: A redirect that arrives in the cycle after an unmatched redirect cancels the older one's pending result. Only the newer redirect's result appears on the output.
- R8: Each redirect produces `out_vld` for exactly one cycle. Early requests alone never raise `out_vld`.
- R9: An early request that arrives in the same cycle as a redirect replaces the held candidates. The redirect in the following cycle is matched only against the new candidates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| early_vld | input | 1 | Early candidate set is valid |
| early_sel | input | 4 | One-hot mask of the paths that carry a candidate |
| early_idx | input | 24 | Four 6-bit candidate queue indices, path i at bits [6i+5:6i] |
| redir_vld | input | 1 | Final redirect valid |
| redir_idx | input | 6 | Arbitrated queue index of the final redirect |
| ahd_rd_en | output | 4 | Per-path read enables to the recovery storage |
| ahd_rd_addr | output | 24 | Per-path read addresses |
| ahd_rd_data | input | 128 | Per-path read data, one cycle after the enable |
| nrm_rd_en | output | 1 | Ordinary read enable on an unmatched redirect |
| nrm_rd_addr | output | 6 | Ordinary read address |
| nrm_rd_data | input | 32 | Ordinary read data, one cycle after the enable |
| out_vld | output | 1 | Recovery record valid |
| out_data | output | 32 | Recovery record |

## Verification
The main function is exercised with candidate sets that differ in which paths are enabled and in where the winning index sits. The cases cover a single enabled path, all four enabled, and two enabled paths carrying the same index. They also include the extreme indices 0 and 63. Each stored record is a distinct function of its index, so a record from the wrong path or a stale read shows up as a data mismatch. Further cases separate a true match from near-misses: an equal index on a disabled path, a set with `early_vld` low, and a redirect one cycle too late. In each of these the output arrives on the ordinary read's later cycle instead. Directed sequences run back-to-back redirects and an early request that lands on a redirect cycle. These check that the older result is cancelled and that the newer candidates replace the held ones.

// File: rtl/early_redirect_sel.sv
module early_redirect_sel #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 32,
  parameter int NPATH  = 4,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    early_vld,
  input  logic [NPATH-1:0]        early_sel,
  input  logic [NPATH*IDX_W-1:0]  early_idx,
  input  logic                    redir_vld,
  input  logic [IDX_W-1:0]        redir_idx,
  output logic [NPATH-1:0]        ahd_rd_en,
  output logic [NPATH*IDX_W-1:0]  ahd_rd_addr,
  input  logic [NPATH*DATA_W-1:0] ahd_rd_data,
  output logic                    nrm_rd_en,
  output logic [IDX_W-1:0]        nrm_rd_addr,
  input  logic [DATA_W-1:0]       nrm_rd_data,
  output logic                    out_vld,
  output logic [DATA_W-1:0]       out_data
);

  logic [NPATH-1:0]       mask_q;
  logic [NPATH*IDX_W-1:0] idx_q;
  logic [NPATH-1:0]       hit_vec;
  logic                   hit;
  logic                   pend_q;
  logic [DATA_W-1:0]      pick;

  assign ahd_rd_en   = early_sel & {NPATH{early_vld}};
  assign ahd_rd_addr = early_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      idx_q  <= '0;
    end else begin
      mask_q <= ahd_rd_en;
      idx_q  <= early_idx;
    end
  end

  for (genvar g = 0; g < NPATH; g++) begin : g_cmp
    assign hit_vec[g] = mask_q[g] && (idx_q[g*IDX_W +: IDX_W] == redir_idx);
  end

  assign hit = |hit_vec;

  always_comb begin
    pick = '0;
    for (int i = NPATH-1; i >= 0; i--)
      if (hit_vec[i]) pick = ahd_rd_data[i*DATA_W +: DATA_W];
  end

  assign nrm_rd_en   = redir_vld && !hit;
  assign nrm_rd_addr = redir_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      out_vld  <= 1'b0;
      out_data <= '0;
    end else begin
      pend_q  <= nrm_rd_en;
      out_vld <= (redir_vld && hit) || (pend_q && !redir_vld);
      if (redir_vld && hit)
        out_data <= pick;
      else if (pend_q && !redir_vld)
        out_data <= nrm_rd_data;
    end
  end

  // R3
  hit_deliver_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_vld && !nrm_rd_en) |=> out_vld);

  // R5
  miss_deliver_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nrm_rd_en ##1 !redir_vld) |=> out_vld);

  // R6
  match_needs_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_vld && !nrm_rd_en) |-> $past(early_vld));

  // R7
  stale_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(nrm_rd_en) && redir_vld && nrm_rd_en) |=> !out_vld);

  // R8
  out_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> ($past(redir_vld) || $past(redir_vld, 2)));

endmodule

// File: tb/sim_early_redirect_sel.sv
`timescale 1ns/1ps
module sim_early_redirect_sel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        early_vld = 1'b0;
  logic [3:0]  early_sel = '0;
  logic [23:0] early_idx = '0;
  logic        redir_vld = 1'b0;
  logic [5:0]  redir_idx = '0;
  logic [3:0]  ahd_rd_en;
  logic [23:0] ahd_rd_addr;
  logic [127:0] ahd_rd_data = '0;
  logic        nrm_rd_en;
  logic [5:0]  nrm_rd_addr;
  logic [31:0] nrm_rd_data = '0;
  logic        out_vld;
  logic [31:0] out_data;

  int total = 0;
  int fails = 0;

  always #2 clk = ~clk;

  early_redirect_sel u0 (
    .clk(clk), .rst_n(rst_n), .early_vld(early_vld), .early_sel(early_sel),
    .early_idx(early_idx), .redir_vld(redir_vld), .redir_idx(redir_idx),
    .ahd_rd_en(ahd_rd_en), .ahd_rd_addr(ahd_rd_addr), .ahd_rd_data(ahd_rd_data),
    .nrm_rd_en(nrm_rd_en), .nrm_rd_addr(nrm_rd_addr), .nrm_rd_data(nrm_rd_data),
    .out_vld(out_vld), .out_data(out_data)
  );

  function automatic logic [31:0] rec(input logic [5:0] a);
    return 32'h5A00_0000 + 32'(a) * 32'h0001_0203;
  endfunction

  always_ff @(posedge clk) begin
    for (int p = 0; p < 4; p++)
      if (ahd_rd_en[p]) ahd_rd_data[p*32 +: 32] <= rec(ahd_rd_addr[p*6 +: 6]);
    if (nrm_rd_en) nrm_rd_data <= rec(nrm_rd_addr);
  end

  function automatic logic [35:0] mk(input logic v, input logic late, input logic [3:0] s,
      input logic [5:0] i0, input logic [5:0] i1, input logic [5:0] i2,
      input logic [5:0] i3, input logic [5:0] r);
    return {v, late, s, i3, i2, i1, i0, r};
  endfunction

  localparam int NV = 10;
  localparam logic [35:0] VEC [NV] = '{
    mk(1, 0, 4'b0001,  5,  0,  0,  0,  5),
    mk(1, 0, 4'b0100,  0,  0, 63,  0, 63),
    mk(1, 0, 4'b1111,  1,  2,  3,  4,  4),
    mk(1, 0, 4'b1111,  7,  8,  9, 10, 11),
    mk(1, 0, 4'b0010, 20, 21,  0,  0, 20),
    mk(0, 0, 4'b1111,  3,  3,  3,  3,  3),
    mk(1, 0, 4'b1010,  0,  0,  0,  0,  0),
    mk(1, 1, 4'b0001, 12,  0,  0,  0, 12),
    mk(1, 0, 4'b1000,  0,  0,  0, 33, 33),
    mk(1, 0, 4'b0110,  0, 40, 40,  0, 40)
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    early_vld = 0; early_sel = '0; redir_vld = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 out_vld in reset", 32'(out_vld), 0);
    chk("R1 nrm_rd_en in reset", 32'(nrm_rd_en), 0);
    chk("R1 ahd_rd_en in reset", 32'(ahd_rd_en), 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk); #1;
    chk("R1 out_vld after reset", 32'(out_vld), 0);

    for (int k = 0; k < NV; k++) begin
      logic [35:0] v;
      logic hit;
      v = VEC[k];
      hit = 0;
      for (int p = 0; p < 4; p++)
        if (v[35] && !v[34] && v[30+p] && v[6+p*6 +: 6] == v[5:0]) hit = 1;
      @(negedge clk);
      early_vld = v[35]; early_sel = v[33:30]; early_idx = v[29:6];
      #1;
      chk("R2 ahd_rd_en", 32'(ahd_rd_en), 32'(v[35] ? v[33:30] : 4'b0));
      chk("R2 ahd_rd_addr", 32'(ahd_rd_addr), 32'(v[29:6]));
      if (v[34]) begin
        @(negedge clk); idle();
      end
      @(negedge clk);
      idle(); redir_vld = 1; redir_idx = v[5:0];
      #1;
      chk(hit ? "R3 no ordinary read" : "R4 R5 R6 ordinary read", 32'(nrm_rd_en), 32'(!hit));
      if (!hit) chk("R5 ordinary addr", 32'(nrm_rd_addr), 32'(v[5:0]));
      @(negedge clk); idle(); #1;
      chk(hit ? "R3 out_vld" : "R5 gap cycle", 32'(out_vld), 32'(hit));
      if (hit) chk("R3 out_data", out_data, rec(v[5:0]));
      @(negedge clk); #1;
      chk(hit ? "R8 single pulse" : "R5 out_vld", 32'(out_vld), 32'(!hit));
      if (!hit) chk("R5 out_data", out_data, rec(v[5:0]));
      @(negedge clk); #1;
      chk("R8 out_vld low", 32'(out_vld), 0);
    end

    // R8: early requests alone never raise out_vld
    @(negedge clk); early_vld = 1; early_sel = 4'b1111; early_idx = {6'd1, 6'd2, 6'd3, 6'd4};
    @(negedge clk); idle();
    @(negedge clk); #1;
    chk("R8 no redirect", 32'(out_vld), 0);
    @(negedge clk); #1;
    chk("R8 no redirect later", 32'(out_vld), 0);

    // R9: early request in the redirect cycle replaces held candidates
    @(negedge clk); early_vld = 1; early_sel = 4'b0001; early_idx = 24'(6'd50);
    @(negedge clk); early_idx = 24'(6'd9); redir_vld = 1; redir_idx = 6'd50;
    #1; chk("R9 first redirect matches", 32'(nrm_rd_en), 0);
    @(negedge clk); idle(); redir_vld = 1; redir_idx = 6'd50;
    #1;
    chk("R9 old candidate replaced", 32'(nrm_rd_en), 1);
    chk("R9 first result", out_data, rec(6'd50));
    @(negedge clk); idle(); #1;
    chk("R9 gap", 32'(out_vld), 0);
    @(negedge clk); #1;
    chk("R9 ordinary result", out_data, rec(6'd50));
    chk("R9 ordinary valid", 32'(out_vld), 1);

    // R7: newer redirect cancels a pending unmatched one
    @(negedge clk); idle();
    @(negedge clk); early_vld = 1; early_sel = 4'b0001; early_idx = 24'(6'd9);
    redir_vld = 1; redir_idx = 6'd30;
    #1; chk("R7 older redirect misses", 32'(nrm_rd_en), 1);
    @(negedge clk); idle(); redir_vld = 1; redir_idx = 6'd9;
    #1; chk("R7 newer redirect matches", 32'(nrm_rd_en), 0);
    @(negedge clk); idle(); #1;
    chk("R7 newer result valid", 32'(out_vld), 1);
    chk("R7 newer result data", out_data, rec(6'd9));
    @(negedge clk); #1;
    chk("R7 older result dropped", 32'(out_vld), 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule